// File: doc/BRIEF.md
# Reset Source Capture Register

This block is an 8-bit control and status register that remembers which event caused the most recent system reset. It also keeps the enable bits that decide whether the optional sources may cause a reset. These sources are the supply monitor, the comparator, the missing-clock indication and the USB reset request. The pin, watchdog and flash-error sources always cause a reset. A power-on pulse resets the block itself. Every other accepted event raises a system reset request pulse of fixed length.

Several bit positions have two meanings. A plain read returns the cause flags. A write updates the enable latches. A read-modify-write read returns the enable latches for the dual-meaning bits, so software that modifies the register and writes it back never copies flags into enables. Writing 1 to the software bit forces a reset. The bus is a plain single-register strobe interface with no handshake: reads are combinational and writes take effect at the next clock edge.

Top module: `rst_cause_reg`

## Requirements
- R1: The bit layout, from bit 7 to bit 0, is: USB (7), flash error (6), comparator (5), software (4), watchdog (3), missing clock (2), supply/power-on (1), pin (0). With `rd_en_i`=1 and `rmw_i`=0, `rd_data_o` returns the cause flags. After any reset exactly one flag is set, the one for the winning cause. With neither strobe set, `rd_data_o` is 0.
- R2: With `rmw_i`=1 (whatever `rd_en_i` is), `rd_data_o` bits 7, 5, 2 and 1 come from the enable latches, bit 4 reads 0, and bits 6, 3 and 0 come from the cause flags.
- R3: Bits 6, 3 and 0 have no enable latch, and the write data on them is ignored.
- R4: A write with bit 4 = 1 forces a system reset, after which the plain read returns 0x10. That write leaves the enable latches unchanged. A write with bit 4 = 0 causes no reset.
- R5: A reset other than power-on leaves the enable latches unchanged.
- R6: `por_i` acts asynchronously. It sets the flags to 0x02 and clears every enable. It holds `sys_rst_o` high while asserted, and for RST_CYCLES (default 4) clock edges after release.
- R7: An event sampled at a clock edge updates the flags at that edge. `sys_rst_o` is then high for exactly RST_CYCLES cycles, starting with that edge.
- R8: When several events are sampled at the same edge, the winner follows this order: supply monitor, pin, watchdog, missing clock, comparator, flash error, USB, software force.
- R9: The comparator causes a reset only when enable bit 5 is 1 and `cmp_out_i` is 0.
- R10: The missing-clock (enable bit 2), USB (enable bit 7) and supply-low (enable bit 1) inputs cause a reset only when their enable is 1. Otherwise they are ignored.
- R11: While `sys_rst_o` is high, all events and writes are ignored.
- R12: A non-forcing write updates the enables at the next edge. A write sampled at the same edge as an accepted event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| pin_rst_i | input | 1 | External pin reset event |
| wdt_tmo_i | input | 1 | Watchdog timeout event |
| flash_err_i | input | 1 | Flash access error event |
| cmp_out_i | input | 1 | Comparator output; low requests a reset |
| clk_miss_i | input | 1 | Missing-clock indication |
| usb_rst_i | input | 1 | USB reset request |
| vdd_low_i | input | 1 | Supply monitor low indication |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Plain read strobe |
| rmw_i | input | 1 | Read-modify-write read strobe |
| rd_data_o | output | 8 | Read data, combinational |
| sys_rst_o | output | 1 | System reset request |

## Verification
Read data is combinational. The bench therefore samples it in the same half cycle in which it raises a strobe, one time step later. An event or write presented before a rising edge changes the flags and enables at that edge. At that same edge `sys_rst_o` rises, and it stays high for four edges. The bench drives every input at a falling edge and counts `sys_rst_o` at each later falling edge until it drops, so the pulse length is measured exactly. For the power-on case, the sample taken at release is part of that count. Reads that follow an event are made only after the pulse has ended, which also checks that the captured state survived the pulse.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int REG_W   = 8;
  localparam int B_PIN   = 0;
  localparam int B_PWR   = 1;
  localparam int B_MCD   = 2;
  localparam int B_WDT   = 3;
  localparam int B_SW    = 4;
  localparam int B_CMP   = 5;
  localparam int B_FLASH = 6;
  localparam int B_USB   = 7;

  // bits backed by an enable latch
  localparam logic [REG_W-1:0] ENABLE_MASK    = (REG_W'(1) << B_USB) | (REG_W'(1) << B_CMP) |
                                                (REG_W'(1) << B_MCD) | (REG_W'(1) << B_PWR);
  // bits that are only cause flags
  localparam logic [REG_W-1:0] FLAG_ONLY_MASK = (REG_W'(1) << B_FLASH) | (REG_W'(1) << B_WDT) |
                                                (REG_W'(1) << B_PIN);
  localparam logic [REG_W-1:0] POR_FLAGS      = REG_W'(1) << B_PWR;

  // bit position of the source holding a given priority rank (0 = highest)
  function automatic int prio_bit(input int rank);
    case (rank)
      0:       return B_PWR;
      1:       return B_PIN;
      2:       return B_WDT;
      3:       return B_MCD;
      4:       return B_CMP;
      5:       return B_FLASH;
      6:       return B_USB;
      default: return B_SW;
    endcase
  endfunction
endpackage

// File: rtl/rcr_detect.sv
module rcr_detect
  import rcr_pkg::*;
(
  input  logic [REG_W-1:0] en_i,
  input  logic             pin_rst_i,
  input  logic             wdt_tmo_i,
  input  logic             flash_err_i,
  input  logic             cmp_out_i,
  input  logic             clk_miss_i,
  input  logic             usb_rst_i,
  input  logic             vdd_low_i,
  input  logic             force_i,
  output logic [REG_W-1:0] req_o
);
  always_comb begin
    req_o          = '0;
    req_o[B_PWR]   = vdd_low_i & en_i[B_PWR];
    req_o[B_PIN]   = pin_rst_i;
    req_o[B_WDT]   = wdt_tmo_i;
    req_o[B_MCD]   = clk_miss_i & en_i[B_MCD];
    req_o[B_CMP]   = ~cmp_out_i & en_i[B_CMP];
    req_o[B_FLASH] = flash_err_i;
    req_o[B_USB]   = usb_rst_i & en_i[B_USB];
    req_o[B_SW]    = force_i;
  end
endmodule

// File: rtl/rcr_arbiter.sv
module rcr_arbiter
  import rcr_pkg::*;
#(
  parameter int N = REG_W
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic seen;
  always_comb begin
    grant_o = '0;
    seen    = 1'b0;
    for (int r = 0; r < N; r++) begin
      if (req_i[prio_bit(r)] && !seen) begin
        grant_o[prio_bit(r)] = 1'b1;
        seen                 = 1'b1;
      end
    end
  end
  assign any_o = seen;
endmodule

// File: rtl/rcr_pulse.sv
module rcr_pulse #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)               cnt_q <= CW'(CYCLES);
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             pin_rst_i,
  input  logic             wdt_tmo_i,
  input  logic             flash_err_i,
  input  logic             cmp_out_i,
  input  logic             clk_miss_i,
  input  logic             usb_rst_i,
  input  logic             vdd_low_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             rmw_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             sys_rst_o
);
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] flag_q;
  logic [REG_W-1:0] req;
  logic [REG_W-1:0] grant;
  logic             any_req;
  logic             busy;
  logic             take;
  logic             wr_ok;
  logic             force_req;
  logic             unused_wr_bits;

  assign force_req      = wr_en_i & wr_data_i[B_SW];
  assign unused_wr_bits = ^(wr_data_i & FLAG_ONLY_MASK);

  rcr_detect u_detect (
    .en_i       (en_q),
    .pin_rst_i  (pin_rst_i),
    .wdt_tmo_i  (wdt_tmo_i),
    .flash_err_i(flash_err_i),
    .cmp_out_i  (cmp_out_i),
    .clk_miss_i (clk_miss_i),
    .usb_rst_i  (usb_rst_i),
    .vdd_low_i  (vdd_low_i),
    .force_i    (force_req),
    .req_o      (req)
  );

  rcr_arbiter #(.N(REG_W)) u_arb (
    .req_i  (req),
    .grant_o(grant),
    .any_o  (any_req)
  );

  rcr_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .start_i(take),
    .busy_o (busy)
  );

  assign take  = any_req & ~busy;
  assign wr_ok = wr_en_i & ~busy & ~any_req;

  // cause flags: cleared and replaced by the winner on every accepted event
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)     flag_q <= POR_FLAGS;
    else if (take) flag_q <= grant;
  end

  // enable latches exist only where the mask asks for one
  for (genvar b = 0; b < REG_W; b++) begin : g_en
    logic bit_q;
    if (ENABLE_MASK[b]) begin : g_latch
      always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)      bit_q <= 1'b0;
        else if (wr_ok) bit_q <= wr_data_i[b];
      end
    end else begin : g_none
      assign bit_q = 1'b0;
    end
    assign en_q[b] = bit_q;
  end

  always_comb begin
    if (rmw_i)        rd_data_o = (en_q & ENABLE_MASK) | (flag_q & FLAG_ONLY_MASK);
    else if (rd_en_i) rd_data_o = flag_q;
    else              rd_data_o = '0;
  end

  assign sys_rst_o = busy;
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rcr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input logic             clk_i,
  input logic             por_i,
  input logic             cmp_out_i,
  input logic             rd_en_i,
  input logic             rmw_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             sys_rst_o,
  input logic [REG_W-1:0] flag_q,
  input logic [REG_W-1:0] en_q
);
  localparam int HW = $clog2(RST_CYCLES + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)          hi_cnt <= '0;
    else if (sys_rst_o) hi_cnt <= hi_cnt + HW'(1);
    else                hi_cnt <= '0;
  end

  // R7
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (por_i)
    sys_rst_o |-> hi_cnt < HW'(RST_CYCLES));

  // R7
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(sys_rst_o) |-> hi_cnt == HW'(RST_CYCLES));

  // R1
  onehot_flag_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (rd_en_i && !rmw_i) |-> $countones(rd_data_o) == 1);

  // R4
  rmw_force_zero_chk: assert property (@(posedge clk_i) disable iff (por_i)
    rmw_i |-> !rd_data_o[B_SW]);

  // R11
  hold_in_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
    sys_rst_o |=> ($stable(flag_q) && $stable(en_q)));

  // R9
  cmp_gate_chk: assert property (@(posedge clk_i) disable iff (por_i)
    ($rose(sys_rst_o) && flag_q[B_CMP]) |-> ($past(en_q[B_CMP]) && !$past(cmp_out_i)));
endmodule

bind rst_cause_reg rst_cause_reg_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .por_i    (por_i),
  .cmp_out_i(cmp_out_i),
  .rd_en_i  (rd_en_i),
  .rmw_i    (rmw_i),
  .rd_data_o(rd_data_o),
  .sys_rst_o(sys_rst_o),
  .flag_q   (flag_q),
  .en_q     (en_q)
);

// File: tb/rst_cause_reg_tb.sv
`timescale 1ns/1ps
module rst_cause_reg_tb;
  logic clk = 1'b0;
  logic por = 1'b1;
  logic pin = 1'b0, wdt = 1'b0, flash = 1'b0, cmp = 1'b1;
  logic miss = 1'b0, usb = 1'b0, vdd = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rmw = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic sys_rst;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_reg u_dut (
    .clk_i(clk), .por_i(por), .pin_rst_i(pin), .wdt_tmo_i(wdt),
    .flash_err_i(flash), .cmp_out_i(cmp), .clk_miss_i(miss),
    .usb_rst_i(usb), .vdd_low_i(vdd), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rmw_i(rmw), .rd_data_o(rd_data), .sys_rst_o(sys_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    pin = 1'b0; wdt = 1'b0; flash = 1'b0; cmp = 1'b1;
    miss = 1'b0; usb = 1'b0; vdd = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // counts falling edges with sys_rst high after a stimulus applied at a falling edge
  task automatic measure(output int hi);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      clear_inputs();
      if (sys_rst) hi++;
      else break;
    end
  endtask

  task automatic rd_plain(output logic [7:0] v);
    rd_en = 1'b1; rmw = 1'b0; #1; v = rd_data; rd_en = 1'b0;
  endtask

  task automatic rd_rmw(output logic [7:0] v);
    rmw = 1'b1; #1; v = rd_data; rmw = 1'b0;
  endtask

  task automatic write(input logic [7:0] d, output int hi);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    measure(hi);
  endtask

  task automatic do_por();
    int hi;
    logic [7:0] v;
    @(negedge clk); por = 1'b1;
    @(negedge clk); @(negedge clk); por = 1'b0;
    hi = sys_rst ? 1 : 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sys_rst) hi++;
      else break;
    end
    chk("R6 por pulse length", hi, 4);
    rd_plain(v); chk("R6 plain after por", v, 8'h02);
    rd_rmw(v);   chk("R6 rmw after por", v, 8'h00);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    do_por();
    #1; chk("R1 idle read is zero", rd_data, 8'h00);
  endtask

  task automatic t_write_enables();
    int hi;
    logic [7:0] v;
    write(8'hEF, hi);
    chk("R4 bit4=0 write no reset", hi, 0);
    rd_rmw(v);   chk("R2 R3 rmw shows enables", v, 8'hA6);
    rd_plain(v); chk("R3 plain keeps flags", v, 8'h02);
  endtask

  task automatic t_watchdog();
    int hi;
    logic [7:0] v;
    @(negedge clk); wdt = 1'b1;
    measure(hi);
    chk("R7 watchdog pulse length", hi, 4);
    rd_plain(v); chk("R1 watchdog flag", v, 8'h08);
    rd_rmw(v);   chk("R5 enables kept", v, 8'hAE);
  endtask

  task automatic t_priority();
    int hi;
    logic [7:0] v;
    @(negedge clk); pin = 1'b1; wdt = 1'b1; flash = 1'b1;
    measure(hi);
    rd_plain(v); chk("R8 pin beats watchdog", v, 8'h01);
    @(negedge clk); wdt = 1'b1; flash = 1'b1; usb = 1'b1; cmp = 1'b0;
    measure(hi);
    rd_plain(v); chk("R8 watchdog beats comparator", v, 8'h08);
    @(negedge clk); flash = 1'b1; usb = 1'b1;
    measure(hi);
    rd_plain(v); chk("R8 flash beats usb", v, 8'h40);
    @(negedge clk); usb = 1'b1;
    measure(hi);
    rd_plain(v); chk("R10 usb enabled", v, 8'h80);
  endtask

  task automatic t_sw_force();
    int hi;
    logic [7:0] v;
    write(8'h10, hi);
    chk("R4 force pulse", hi, 4);
    rd_plain(v); chk("R4 force flag", v, 8'h10);
    rd_rmw(v);   chk("R4 force keeps enables", v, 8'hA6);
  endtask

  task automatic t_comparator();
    int hi;
    logic [7:0] v;
    @(negedge clk); cmp = 1'b0;
    measure(hi);
    rd_plain(v); chk("R9 comparator low enabled", v, 8'h20);
  endtask

  task automatic t_blocked();
    logic [7:0] v;
    @(negedge clk); wdt = 1'b1;
    @(negedge clk); wdt = 1'b0; pin = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); clear_inputs();
    repeat (6) @(negedge clk);
    rd_plain(v); chk("R11 event ignored in pulse", v, 8'h08);
    rd_rmw(v);   chk("R11 write ignored in pulse", v, 8'hAE);
  endtask

  task automatic t_same_cycle();
    int hi;
    logic [7:0] v;
    @(negedge clk); pin = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    measure(hi);
    rd_rmw(v); chk("R12 write dropped with event", v, 8'hA7);
  endtask

  task automatic t_disabled();
    int hi;
    logic [7:0] v;
    write(8'h00, hi);
    rd_rmw(v); chk("R12 enables cleared by write", v, 8'h01);
    @(negedge clk); miss = 1'b1; cmp = 1'b0; usb = 1'b1; vdd = 1'b1;
    measure(hi);
    chk("R10 R9 disabled sources no reset", hi, 0);
    rd_plain(v); chk("R10 flags unchanged", v, 8'h01);
  endtask

  task automatic t_mcd_supply();
    int hi;
    logic [7:0] v;
    write(8'h04, hi);
    @(negedge clk); miss = 1'b1;
    measure(hi);
    rd_plain(v); chk("R10 missing clock enabled", v, 8'h04);
    write(8'h02, hi);
    @(negedge clk); vdd = 1'b1;
    measure(hi);
    rd_plain(v); chk("R10 supply low enabled", v, 8'h02);
    rd_rmw(v);   chk("R5 supply enable kept", v, 8'h02);
  endtask

  task automatic t_por_again();
    int hi;
    write(8'hA6, hi);
    do_por();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_write_enables();
    t_watchdog();
    t_priority();
    t_sw_force();
    t_comparator();
    t_blocked();
    t_same_cycle();
    t_disabled();
    t_mcd_supply();
    t_por_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule